// File: doc/BRIEF.md
# Readout Link Fragment Framer with Word Spy

This block takes one event's worth of data words from an upstream source and wraps them into a single framed fragment for an outbound point-to-point readout link. Each fragment opens with a begin control word and closes with an end control word. In between come a header with the event number and bunch counter, the data words unchanged, and a trailer holding the number of data words. A control flag travels with every link word so that the receiver can tell the two control words from payload.

The link is driven by a write strobe. The strobe is held off whenever the link reports full or down, so a stalled link only delays the fragment and never corrupts it. A synchronous reset request from the link side drops any fragment in progress and returns the framer to idle. Software on a small register bus can ask for an empty fragment (header and trailer, no data) when upstream has nothing to give. Software can also enable a spy FIFO that records every link word together with its control flag and a code for the word's position in the fragment, and read that record back.

The upstream input is valid/ready. A word moves when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high only while the framer is in its data phase and the link can take a word, so back-pressure from the link reaches the source in the same cycle. The source must hold `in_data` and `in_last` stable while `in_valid` is high and `in_ready` is low. Link, reset-request and bus pins are plain level signals sampled at the rising clock edge.

Top module: `frag_framer`

## Requirements
- R1: A fragment is, in order: a begin word (`lnk_ctrl`=1, data `BOF_CODE`, default 32'hB0F0_0001), a header, the data words in arrival order (`lnk_ctrl`=0), a trailer, and an end word (`lnk_ctrl`=1, data `EOF_CODE`, default 32'hE0F0_0002). The cycle after an end word carries no link word. All words between the begin and end words have `lnk_ctrl`=0.
- R2: While `lnk_full` or `lnk_down` is high, `lnk_wen` and `in_ready` are low. When both are low again, the fragment continues with no word lost or repeated.
- R3: The header word is {event number, 8-bit bunch counter}, with the event number in bits 31:8 and the bunch counter in bits 7:0. Both values are taken from `evt_num` and `bunch` in the cycle the framer leaves idle.
- R4: A data word with `in_last`=1 ends the data phase. The trailer's data field, zero-extended, holds the number of data words accepted in that fragment.
- R5: Writing 1 to bit 1 of register 0 requests an empty fragment. Once the framer is idle, it emits a begin word, a header, a trailer of 0 and an end word, and it consumes no input word. Reading register 0 returns the spy enable in bit 0 and the pending request in bit 1.
- R6: With `user_reset` high at an edge, the fragment in progress is dropped, any pending empty request is cleared, and the following cycle carries no link word. The next fragment begins with a begin word.
- R7: When the spy is enabled (bit 0 of register 0), every link word is stored. Register 2 reads the oldest entry's data. Register 3 reads its tag, with the position code in bits 3:1 (1 begin, 2 header, 3 data, 4 trailer, 5 end) and the control flag in bit 0. A read of register 3 removes the entry.
- R8: When the spy is disabled, no link word is stored, and the fill level (register 1 bits 15:0) does not change.
- R9: When the spy is full, further words are not stored and the link is never held back. The sticky overflow bit (register 1 bit 16) is set, and it stays set until software writes register 1.
- R10: After reset, `lnk_wen` and `in_ready` are low, the spy level is 0, the spy-empty bit (register 1 bit 17) is 1, and register 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream data word valid |
| in_ready | output | 1 | Framer accepts the upstream word this cycle |
| in_data | input | DW | Upstream data word |
| in_last | input | 1 | Marks the final data word of the event |
| evt_num | input | DW-8 | Event number for the header |
| bunch | input | 8 | Bunch counter for the header |
| lnk_full | input | 1 | Link cannot take a word |
| lnk_down | input | 1 | Link is not up |
| user_reset | input | 1 | Link-side request to return to idle |
| lnk_wen | output | 1 | Link word strobe |
| lnk_ctrl | output | 1 | Link word is a control word |
| lnk_data | output | DW | Link word |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 2 | Register index |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for the addressed register |

## Verification
The assertions assume the following about the inputs:
- Upstream holds a word stable until it is taken.
- `user_reset` is a synchronous level.
- A read of register 3 is issued as a single-cycle strobe.

Under those assumptions the link strobe never coincides with full or down, every accepted input word leaves on the link in the same cycle, and the overflow bit is sticky. The bench drives every input a moment after the rising edge and samples a moment before the next one. It holds `in_valid` with steady data until it sees `in_ready`. Full and down follow fixed periodic patterns that change only between edges. Each register access is a single one-cycle bus strobe.

// File: rtl/frag_pkg.sv
package frag_pkg;
  localparam int unsigned KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    K_IDLE = 3'd0,
    K_BOF  = 3'd1,
    K_HDR  = 3'd2,
    K_DATA = 3'd3,
    K_TRL  = 3'd4,
    K_EOF  = 3'd5
  } kind_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_SDAT = 2'd2;
  localparam logic [1:0] A_STAG = 2'd3;

  localparam int unsigned STAT_OVF_BIT = 16;
  localparam int unsigned STAT_EMP_BIT = 17;
endpackage

// File: rtl/frag_seq.sv
module frag_seq
  import frag_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned BCW   = 8,
  parameter int unsigned CNT_W = 16,
  parameter logic [DW-1:0] BOF_CODE = 32'hB0F0_0001,
  parameter logic [DW-1:0] EOF_CODE = 32'hE0F0_0002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              user_reset,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_data,
  input  logic              in_last,
  input  logic [DW-BCW-1:0] evt_num,
  input  logic [BCW-1:0]    bunch,
  input  logic              empty_pend,
  output logic              empty_take,
  input  logic              lnk_full,
  input  logic              lnk_down,
  output logic              lnk_wen,
  output logic              lnk_ctrl,
  output logic [DW-1:0]     lnk_data,
  output logic [KIND_W-1:0] word_kind
);
  localparam int unsigned PAD_W = DW - CNT_W;

  kind_e            st_q, st_nx;
  logic             empty_q;
  logic [DW-1:0]    hdr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             go;
  logic             beat;

  assign go         = !lnk_full && !lnk_down;
  assign beat       = (st_q == K_DATA) && go && in_valid;
  assign empty_take = (st_q == K_IDLE) && empty_pend && !user_reset;
  assign word_kind  = st_q;

  always_comb begin
    lnk_wen  = 1'b0;
    lnk_ctrl = 1'b0;
    lnk_data = '0;
    in_ready = 1'b0;
    unique case (st_q)
      K_BOF: begin
        lnk_wen  = go;
        lnk_ctrl = 1'b1;
        lnk_data = BOF_CODE;
      end
      K_HDR: begin
        lnk_wen  = go;
        lnk_data = hdr_q;
      end
      K_DATA: begin
        in_ready = go;
        lnk_wen  = beat;
        lnk_data = in_data;
      end
      K_TRL: begin
        lnk_wen  = go;
        lnk_data = {{PAD_W{1'b0}}, cnt_q};
      end
      K_EOF: begin
        lnk_wen  = go;
        lnk_ctrl = 1'b1;
        lnk_data = EOF_CODE;
      end
      default: ;
    endcase
  end

  always_comb begin
    st_nx = st_q;
    unique case (st_q)
      K_IDLE: if (empty_pend || in_valid) st_nx = K_BOF;
      K_BOF:  if (go) st_nx = K_HDR;
      K_HDR:  if (go) st_nx = empty_q ? K_TRL : K_DATA;
      K_DATA: if (beat && in_last) st_nx = K_TRL;
      K_TRL:  if (go) st_nx = K_EOF;
      K_EOF:  if (go) st_nx = K_IDLE;
      default: st_nx = K_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= K_IDLE;
      empty_q <= 1'b0;
      hdr_q   <= '0;
      cnt_q   <= '0;
    end else if (user_reset) begin
      st_q    <= K_IDLE;
      empty_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      st_q <= st_nx;
      if (st_q == K_IDLE && st_nx == K_BOF) begin
        hdr_q   <= {evt_num, bunch};
        empty_q <= empty_pend;
        cnt_q   <= '0;
      end else if (beat) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/frag_spy_fifo.sv
module frag_spy_fifo #(
  parameter int unsigned W     = 36,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_pop,
  output logic [W-1:0]  rd_data,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          ovf,
  input  logic          ovf_clr
);
  localparam logic [LW-1:0] FULL_CNT = LW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [LW-1:0] cnt_q;
  logic          full, wr_en, rd_en;

  assign full    = (cnt_q == FULL_CNT);
  assign empty   = (cnt_q == '0);
  assign wr_en   = wr_req && !full;
  assign rd_en   = rd_pop && !empty;
  assign rd_data = mem[rp_q];
  assign level   = cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf   <= 1'b0;
    end else begin
      if (wr_en) wp_q <= bump(wp_q);
      if (rd_en) rp_q <= bump(rp_q);
      unique case ({wr_en, rd_en})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
      if (wr_req && full) ovf <= 1'b1;
      else if (ovf_clr)   ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/frag_regs.sv
module frag_regs
  import frag_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned LW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              user_reset,
  output logic              spy_en,
  output logic              empty_pend,
  input  logic              empty_take,
  input  logic [LW-1:0]     spy_level,
  input  logic              spy_empty,
  input  logic              spy_ovf,
  input  logic [DW-1:0]     spy_head_data,
  input  logic [KIND_W:0]   spy_head_tag,
  output logic              spy_pop,
  output logic              ovf_clr
);
  logic wr_ctrl;
  logic unused_wdata;

  assign wr_ctrl      = bus_en && bus_we && (bus_addr == A_CTRL);
  assign ovf_clr      = bus_en && bus_we && (bus_addr == A_STAT);
  assign spy_pop      = bus_en && !bus_we && (bus_addr == A_STAG);
  assign unused_wdata = ^bus_wdata[DW-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spy_en     <= 1'b0;
      empty_pend <= 1'b0;
    end else begin
      if (wr_ctrl) spy_en <= bus_wdata[0];
      if (user_reset)                 empty_pend <= 1'b0;
      else if (wr_ctrl && bus_wdata[1]) empty_pend <= 1'b1;
      else if (empty_take)            empty_pend <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL: begin
        bus_rdata[0] = spy_en;
        bus_rdata[1] = empty_pend;
      end
      A_STAT: begin
        bus_rdata[LW-1:0]     = spy_level;
        bus_rdata[STAT_OVF_BIT] = spy_ovf;
        bus_rdata[STAT_EMP_BIT] = spy_empty;
      end
      A_SDAT: bus_rdata = spy_head_data;
      default: bus_rdata[KIND_W:0] = spy_head_tag;
    endcase
  end
endmodule

// File: rtl/frag_framer.sv
module frag_framer
  import frag_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter int unsigned BCW       = 8,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned SPY_DEPTH = 16,
  parameter logic [DW-1:0] BOF_CODE = 32'hB0F0_0001,
  parameter logic [DW-1:0] EOF_CODE = 32'hE0F0_0002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_data,
  input  logic              in_last,
  input  logic [DW-BCW-1:0] evt_num,
  input  logic [BCW-1:0]    bunch,
  input  logic              lnk_full,
  input  logic              lnk_down,
  input  logic              user_reset,
  output logic              lnk_wen,
  output logic              lnk_ctrl,
  output logic [DW-1:0]     lnk_data,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata
);
  localparam int unsigned EW = DW + 1 + KIND_W;
  localparam int unsigned LW = $clog2(SPY_DEPTH + 1);

  logic              empty_pend, empty_take;
  logic              spy_en, spy_pop, ovf_clr;
  logic              spy_empty, spy_ovf;
  logic [LW-1:0]     spy_level;
  logic [KIND_W-1:0] word_kind;
  logic [EW-1:0]     spy_head;

  frag_seq #(
    .DW(DW), .BCW(BCW), .CNT_W(CNT_W),
    .BOF_CODE(BOF_CODE), .EOF_CODE(EOF_CODE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .user_reset(user_reset),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last),
    .evt_num(evt_num), .bunch(bunch),
    .empty_pend(empty_pend), .empty_take(empty_take),
    .lnk_full(lnk_full), .lnk_down(lnk_down),
    .lnk_wen(lnk_wen), .lnk_ctrl(lnk_ctrl), .lnk_data(lnk_data),
    .word_kind(word_kind)
  );

  frag_spy_fifo #(.W(EW), .DEPTH(SPY_DEPTH)) u_spy (
    .clk(clk), .rst_n(rst_n),
    .wr_req(lnk_wen && spy_en),
    .wr_data({word_kind, lnk_ctrl, lnk_data}),
    .rd_pop(spy_pop), .rd_data(spy_head),
    .level(spy_level), .empty(spy_empty),
    .ovf(spy_ovf), .ovf_clr(ovf_clr)
  );

  frag_regs #(.DW(DW), .LW(LW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .user_reset(user_reset),
    .spy_en(spy_en), .empty_pend(empty_pend), .empty_take(empty_take),
    .spy_level(spy_level), .spy_empty(spy_empty), .spy_ovf(spy_ovf),
    .spy_head_data(spy_head[DW-1:0]), .spy_head_tag(spy_head[EW-1:DW]),
    .spy_pop(spy_pop), .ovf_clr(ovf_clr)
  );
endmodule

// File: rtl/frag_framer_chk.sv
module frag_framer_chk #(
  parameter int unsigned DW    = 32,
  parameter int unsigned LW    = 5,
  parameter int unsigned DEPTH = 16,
  parameter logic [DW-1:0] BOF_CODE = 32'hB0F0_0001,
  parameter logic [DW-1:0] EOF_CODE = 32'hE0F0_0002
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] in_data,
  input logic          lnk_full,
  input logic          lnk_down,
  input logic          user_reset,
  input logic          lnk_wen,
  input logic          lnk_ctrl,
  input logic [DW-1:0] lnk_data,
  input logic          bus_en,
  input logic          bus_we,
  input logic [1:0]    bus_addr,
  input logic          spy_ovf,
  input logic [LW-1:0] spy_level
);
  // R2
  p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_full || lnk_down) |-> (!lnk_wen && !in_ready));

  // R1: control flag only on the two framing codes
  p_ctrl_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_wen && lnk_ctrl) |-> (lnk_data == BOF_CODE || lnk_data == EOF_CODE));

  // R1: accepted input goes straight out as a data word
  p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (lnk_wen && !lnk_ctrl && lnk_data == in_data));

  // R1: idle gap after an end word
  p_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_wen && lnk_ctrl && lnk_data == EOF_CODE) |=> !lnk_wen);

  // R6
  p_ureset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    user_reset |=> !lnk_wen);

  // R9: sticky overflow
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (spy_ovf && !(bus_en && bus_we && bus_addr == 2'd1)) |=> spy_ovf);

  // R9: level bounded by depth
  p_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    spy_level <= LW'(DEPTH));
endmodule

bind frag_framer frag_framer_chk #(
  .DW(DW), .LW($clog2(SPY_DEPTH + 1)), .DEPTH(SPY_DEPTH),
  .BOF_CODE(BOF_CODE), .EOF_CODE(EOF_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .lnk_full(lnk_full), .lnk_down(lnk_down),
  .user_reset(user_reset), .lnk_wen(lnk_wen), .lnk_ctrl(lnk_ctrl),
  .lnk_data(lnk_data), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .spy_ovf(spy_ovf), .spy_level(spy_level)
);

// File: tb/frag_framer_test.sv
module frag_framer_test;
  localparam int DW = 32;
  localparam logic [31:0] BOF = 32'hB0F0_0001;
  localparam logic [31:0] EOF = 32'hE0F0_0002;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [31:0] in_data = '0;
  logic [23:0] evt_num = '0;
  logic [7:0]  bunch = '0;
  logic lnk_full, lnk_down;
  logic user_reset = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic in_ready, lnk_wen, lnk_ctrl;
  logic [31:0] lnk_data, bus_rdata;

  frag_framer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .evt_num(evt_num), .bunch(bunch),
    .lnk_full(lnk_full), .lnk_down(lnk_down), .user_reset(user_reset),
    .lnk_wen(lnk_wen), .lnk_ctrl(lnk_ctrl), .lnk_data(lnk_data),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int stall_mode = 0;
  int cyc = 0;
  logic [31:0] mon_d [0:255];
  logic        mon_c [0:255];
  int mon_n = 0;
  bit spy_on = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // flow-control pattern, driven just after the edge
  initial begin
    lnk_full = 1'b0;
    lnk_down = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      lnk_full = (stall_mode == 1 && cyc % 3 == 1) || (stall_mode == 3);
      lnk_down = (stall_mode == 2 && (cyc % 4 >= 2));
    end
  end

  // link monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n && lnk_wen) begin
      if (lnk_full || lnk_down) begin
        n_fail++;
        $display("FAIL R2 actual=%h expected=%h", 1, 0);
      end
      if (mon_n < 256) begin
        mon_d[mon_n] = lnk_data;
        mon_c[mon_n] = lnk_ctrl;
      end
      mon_n++;
    end
  end

  function automatic logic [31:0] dat_of(input int evt, input int i);
    return 32'(evt * 65536 + i * 7 + 3);
  endfunction

  function automatic logic [32:0] exp_word(input int k, input int len, input int evt, input int bc);
    if (k == 0) return {1'b1, BOF};
    if (k == 1) return {1'b0, 24'(evt), 8'(bc)};
    if (k < len + 2) return {1'b0, dat_of(evt, k - 2)};
    if (k == len + 2) return {1'b0, 32'(len)};
    return {1'b1, EOF};
  endfunction

  function automatic logic [3:0] exp_tag(input int k, input int len);
    if (k == 0) return 4'b0011;
    if (k == 1) return 4'b0100;
    if (k < len + 2) return 4'b0110;
    if (k == len + 2) return 4'b1000;
    return 4'b1011;
  endfunction

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    @(posedge clk); #1;
    bus_en = 0;
  endtask

  task automatic wait_words(input int n);
    for (int t = 0; t < 200 && mon_n < n; t++) @(posedge clk);
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic compare(input int len, input int evt, input int bc, input string tag);
    int bad = -1;
    chk(mon_n == len + 4, {tag, " word count"}, 32'(mon_n), 32'(len + 4));
    for (int k = 0; k < len + 4 && k < mon_n; k++) begin
      if (bad < 0 && {mon_c[k], mon_d[k]} != exp_word(k, len, evt, bc)) bad = k;
    end
    if (bad >= 0)
      chk(0, tag, mon_d[bad], exp_word(bad, len, evt, bc));
    else
      chk(1, tag, 0, 0);
  endtask

  task automatic send_frag(input int len, input int evt, input int bc);
    mon_n = 0;
    evt_num = 24'(evt);
    bunch = 8'(bc);
    for (int i = 0; i < len; i++) begin
      in_valid = 1;
      in_data = dat_of(evt, i);
      in_last = (i == len - 1);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1;
    end
    in_valid = 0;
    in_last = 0;
    wait_words(len + 4);
  endtask

  initial begin
    logic [31:0] rd, rt;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(lnk_wen == 0 && in_ready == 0, "R10 outputs idle", {30'b0, lnk_wen, in_ready}, 0);
    bus_read(2'd1, rd);
    chk(rd[15:0] == 0 && rd[17] == 1 && rd[16] == 0, "R10 spy status", rd, 32'h0002_0000);
    bus_read(2'd0, rd);
    chk(rd == 0, "R10 ctrl reg", rd, 0);

    // R1 R3 R4 R2 sweep: lengths x stall patterns, spy off
    for (int m = 0; m < 3; m++) begin
      for (int len = 1; len <= 6; len++) begin
        stall_mode = m;
        send_frag(len, m * 16 + len + 256, 8'hA0 + len);
        compare(len, m * 16 + len + 256, 8'hA0 + len, m == 0 ? "R1 R3 R4 frame" : "R2 stalled frame");
      end
    end
    stall_mode = 0;
    // R8 spy disabled stores nothing
    bus_read(2'd1, rd);
    chk(rd[15:0] == 0, "R8 level with spy off", rd[15:0], 0);

    // R5 empty fragment
    mon_n = 0;
    evt_num = 24'h00ABCD;
    bunch = 8'h3C;
    bus_write(2'd0, 32'h2);
    wait_words(4);
    compare(0, 24'h00ABCD, 8'h3C, "R5 empty fragment");
    bus_read(2'd0, rd);
    chk(rd[1] == 0, "R5 request consumed", rd, 0);

    // R6 user reset mid-fragment, pending empty dropped
    stall_mode = 3;
    mon_n = 0;
    in_valid = 1; in_data = 32'h1234_5678; in_last = 1;
    repeat (5) @(posedge clk);
    #1;
    bus_write(2'd0, 32'h2);
    user_reset = 1; in_valid = 0; in_last = 0;
    @(posedge clk); #1;
    user_reset = 0;
    stall_mode = 0;
    repeat (12) @(posedge clk);
    #1;
    chk(mon_n == 0, "R6 no word after reset", 32'(mon_n), 0);
    bus_read(2'd0, rd);
    chk(rd[1] == 0, "R6 empty request cleared", rd, 0);
    send_frag(2, 77, 8'h11);
    compare(2, 77, 8'h11, "R6 fragment after reset");

    // R7 spy readback
    bus_write(2'd0, 32'h1);
    stall_mode = 1;
    send_frag(3, 500, 8'h5E);
    stall_mode = 0;
    compare(3, 500, 8'h5E, "R7 frame with spy");
    bus_read(2'd1, rd);
    chk(rd[15:0] == 7, "R7 spy level", rd[15:0], 7);
    for (int k = 0; k < 7; k++) begin
      bus_read(2'd2, rd);
      bus_read(2'd3, rt);
      chk(rd == exp_word(k, 3, 500, 8'h5E)[31:0], "R7 spy data", rd, exp_word(k, 3, 500, 8'h5E)[31:0]);
      chk(rt[3:0] == exp_tag(k, 3), "R7 spy tag", rt, 32'(exp_tag(k, 3)));
    end
    bus_read(2'd1, rd);
    chk(rd[15:0] == 0 && rd[17] == 1, "R7 spy drained", rd, 32'h0002_0000);

    // R9 overflow: 18 words into a 16-entry spy
    send_frag(14, 900, 8'hC3);
    compare(14, 900, 8'hC3, "R9 link not stalled by spy");
    bus_read(2'd1, rd);
    chk(rd[15:0] == 16 && rd[16] == 1, "R9 full and overflow", rd, 32'h0001_0010);
    bus_read(2'd1, rd);
    chk(rd[16] == 1, "R9 overflow sticky", rd, 32'h0001_0010);
    bus_write(2'd1, 32'h0);
    bus_read(2'd1, rd);
    chk(rd[16] == 0 && rd[15:0] == 16, "R9 overflow cleared", rd, 32'h0000_0010);
    bus_read(2'd2, rd);
    chk(rd == BOF, "R9 oldest entry kept", rd, BOF);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule